// File: doc/BRIEF.md
# Per-Channel PCM Companding Law Translator

This block rewrites one 8-bit PCM sample per time slot from the coding law used on the incoming side of a channel to the coding law wanted on its outgoing side. Each sample arrives with its channel number and a valid strobe. The channel number selects a small control entry that says two things. First, whether the channel carries voice (companded audio) or data (plain bit patterns). Second, which input and output conventions apply, chosen independently of each other.

Voice samples are first stripped of their line inversion. They are then expanded to a sign plus a 13-bit linear magnitude and compressed again into the target law, so A-law and µ-law, with or without their customary inversions, can be mixed freely. Data samples never pass through the linear domain: they only receive XOR masks.

The surrounding switch reports whether the current connection is one that is subject to translation. When it is not, the byte goes out untouched. Results appear one clock after the sample, on a registered output.

Top module: `pcm_law_xlate`

## Requirements
- R1: After reset, `out_valid` and `out_byte` are 0, and every channel entry is zero (voice, standard A-law in, standard A-law out), so a translated sample on any channel leaves unchanged.
- R2: A write with `cfg_we` high stores `cfg_word` for channel `cfg_chan`. Bit 4 selects data (1) or voice (0), bits 3:2 give the input law and bits 1:0 the output law. Bits 15:5 have no effect on any later output.
- R3: For a data channel, the output is the input XOR the input-law mask XOR the output-law mask. The mask codes are 00 → 0x00, 01 → 0x55, 10 → 0xAA and 11 → 0xFF.
- R4: For a voice channel, the law code gives both the codec and the line inversion. The codes are 00 → A-law with XOR 0x55, 01 → µ-law with XOR 0x7F, 10 → A-law with no inversion, 11 → µ-law with no inversion. After the inversion is removed, bit 7 is the sign (1 = positive), bits 6:4 are the segment s and bits 3:0 are the step t.
- R5: Voice expansion gives a magnitude in units of 1/8192 of full scale. For µ-law it is (2t+33)·2^s − 33. For A-law it is 4t+2 when s = 0, and (2t+33)·2^s otherwise.
- R6: Voice compression keeps the sign. It picks the largest 7-bit code whose lower decision edge does not exceed the magnitude, then applies the output law's inversion. The lower edges are: µ-law (t+16)·2^(s+1) − 33, clamped at 0; A-law 4t for s = 0, and (t+16)·2^(s+1) otherwise.
- R7: A voice channel whose input and output law codes are equal returns every byte exactly.
- R8: A sample with `in_xlate` low leaves unchanged, whatever the channel entry holds.
- R9: `out_valid` equals `in_valid` of the previous cycle. `out_byte` carries the result one cycle after a valid sample and holds its value while `in_valid` is low.
- R10: When a write and a sample address the same channel in the same cycle, the sample uses the entry held before the write. The new entry applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Channel entry write strobe |
| cfg_chan | input | 5 | Channel written |
| cfg_word | input | 16 | Control word written |
| in_valid | input | 1 | Sample strobe |
| in_chan | input | 5 | Channel of the sample |
| in_byte | input | 8 | Incoming PCM byte |
| in_xlate | input | 1 | High when the connection is subject to translation |
| out_valid | output | 1 | Result strobe |
| out_byte | output | 8 | Translated PCM byte |

## Verification
An entry write and a sample can land on the same channel in the same cycle. The bench provokes this by raising the write strobe and the sample strobe together on one channel, with a new word that changes that channel's data mask. It then expects the old, untranslated byte in that cycle's result and the newly masked byte in the next. The main sweep gives each channel one of the 32 law combinations and drives all 256 byte values through every channel. Each result is compared against a bench model that computes the decision edges and finds the output code by search.

// File: rtl/pcm_law_pkg.sv
package pcm_law_pkg;

  localparam int BYTE_W = 8;
  localparam int MAG_W  = 13;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic       is_data;
    logic [1:0] in_law;
    logic [1:0] out_law;
  } chan_cfg_t;

  // Inversion applied to a data channel byte for one law code.
  function automatic logic [BYTE_W-1:0] data_mask(input logic [1:0] code);
    case (code)
      2'b00:   data_mask = 8'h00;
      2'b01:   data_mask = 8'h55;
      2'b10:   data_mask = 8'hAA;
      default: data_mask = 8'hFF;
    endcase
  endfunction

  // Line inversion of a voice law; bit 0 of the code picks mu-law.
  function automatic logic [BYTE_W-1:0] voice_mask(input logic [1:0] code);
    case (code)
      2'b00:   voice_mask = 8'h55;
      2'b01:   voice_mask = 8'h7F;
      default: voice_mask = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/pcm_ctl_mem.sv
module pcm_ctl_mem
  import pcm_law_pkg::*;
#(
  parameter int CHANNELS = 32,
  localparam int CH_W = $clog2(CHANNELS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_chan,
  input  chan_cfg_t       wr_cfg,
  input  logic [CH_W-1:0] rd_chan,
  output chan_cfg_t       rd_cfg
);

  chan_cfg_t entry_q [CHANNELS];

  for (genvar i = 0; i < CHANNELS; i++) begin : g_entry
    logic      hit;
    chan_cfg_t entry_d;

    always_comb begin
      hit     = wr_en && (wr_chan == CH_W'(i));
      entry_d = hit ? wr_cfg : entry_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) entry_q[i] <= '0;
      else        entry_q[i] <= entry_d;
    end

    a_r2_entry_written: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> entry_q[i] == $past(wr_cfg));
  end

  // Read sees the stored entry; a same-cycle write lands at the edge.
  assign rd_cfg = entry_q[rd_chan];

endmodule

// File: rtl/pcm_law_decode.sv
module pcm_law_decode
  import pcm_law_pkg::*;
(
  input  logic             is_mu,
  input  logic [6:0]       code,
  output logic [MAG_W-1:0] mag
);

  logic [2:0] seg;
  logic [3:0] step;
  logic [13:0] scaled;

  always_comb begin
    seg    = code[6:4];
    step   = code[3:0];
    scaled = (14'({step, 1'b1}) + 14'd32) << seg;
    if (is_mu)            mag = MAG_W'(scaled - 14'd33);
    else if (seg == 3'd0) mag = MAG_W'({step, 2'b10});
    else                  mag = MAG_W'(scaled);
  end

endmodule

// File: rtl/pcm_law_encode.sv
module pcm_law_encode
  import pcm_law_pkg::*;
(
  input  logic             is_mu,
  input  logic [MAG_W-1:0] mag,
  output logic [6:0]       code
);

  logic [13:0] mu_x;
  logic [3:0]  mu_top;
  logic [11:0] a_x;
  logic [3:0]  a_top;
  logic [6:0]  mu_code;
  logic [6:0]  a_code;

  always_comb begin
    mu_x   = 14'(mag) + 14'd33;
    mu_top = 4'd5;
    for (int i = 6; i < 13; i++) if (mu_x[i]) mu_top = 4'(i);
    mu_code = {3'(mu_top - 4'd5), 4'(mu_x >> (mu_top - 4'd4))};

    a_x   = mag[MAG_W-1:1];
    a_top = 4'd4;
    for (int i = 5; i < 12; i++) if (a_x[i]) a_top = 4'(i);
    a_code = {3'(a_top - 4'd4), (a_top == 4'd4) ? a_x[4:1] : 4'(a_x >> (a_top - 4'd4))};

    code = is_mu ? mu_code : a_code;
  end

endmodule

// File: rtl/pcm_law_xlate.sv
module pcm_law_xlate
  import pcm_law_pkg::*;
#(
  parameter int CHANNELS = 32,
  localparam int CH_W = $clog2(CHANNELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic [WORD_W-1:0] cfg_word,
  input  logic              in_valid,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_xlate,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte
);

  // Reset asserts at once and leaves on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q_n = rst_pipe_q[1];

  chan_cfg_t wr_cfg;
  chan_cfg_t sel;
  logic      cfg_unused;

  assign wr_cfg     = chan_cfg_t'(cfg_word[4:0]);
  assign cfg_unused = ^cfg_word[WORD_W-1:5];

  pcm_ctl_mem #(.CHANNELS(CHANNELS)) u_mem (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_en   (cfg_we),
    .wr_chan (cfg_chan),
    .wr_cfg  (wr_cfg),
    .rd_chan (in_chan),
    .rd_cfg  (sel)
  );

  logic [BYTE_W-1:0] canon_in;
  logic [MAG_W-1:0]  lin_mag;
  logic [6:0]        enc_code;
  logic [BYTE_W-1:0] voice_byte;
  logic [BYTE_W-1:0] data_byte;
  logic [BYTE_W-1:0] result;

  assign canon_in = in_byte ^ voice_mask(sel.in_law);

  pcm_law_decode u_dec (
    .is_mu (sel.in_law[0]),
    .code  (canon_in[6:0]),
    .mag   (lin_mag)
  );

  pcm_law_encode u_enc (
    .is_mu (sel.out_law[0]),
    .mag   (lin_mag),
    .code  (enc_code)
  );

  logic              out_valid_d, out_valid_q;
  logic [BYTE_W-1:0] out_byte_d,  out_byte_q;

  always_comb begin
    voice_byte  = {canon_in[7], enc_code} ^ voice_mask(sel.out_law);
    data_byte   = in_byte ^ data_mask(sel.in_law) ^ data_mask(sel.out_law);
    result      = !in_xlate   ? in_byte   :
                  sel.is_data ? data_byte : voice_byte;
    out_valid_d = in_valid;
    out_byte_d  = in_valid ? result : out_byte_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid_q <= 1'b0;
      out_byte_q  <= '0;
    end else begin
      out_valid_q <= out_valid_d;
      out_byte_q  <= out_byte_d;
    end
  end

  assign out_valid = out_valid_q;
  assign out_byte  = out_byte_q;

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |=> out_valid == $past(in_valid));

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> $stable(out_byte));

  a_r8_raw_pass: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid && !in_xlate |=> out_byte == $past(in_byte));

  a_r7_same_voice_law: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid && in_xlate && !sel.is_data && sel.in_law == sel.out_law
    |=> out_byte == $past(in_byte));

  a_r3_same_data_mask: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid && in_xlate && sel.is_data && sel.in_law == sel.out_law
    |=> out_byte == $past(in_byte));

endmodule

// File: tb/tb_pcm_law_xlate.sv
`timescale 1ns/1ps
module tb_pcm_law_xlate;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_chan;
  logic [15:0] cfg_word;
  logic        in_valid;
  logic [4:0]  in_chan;
  logic [7:0]  in_byte;
  logic        in_xlate;
  logic        out_valid;
  logic [7:0]  out_byte;

  int checks = 0;
  int errors = 0;

  pcm_law_xlate dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
    .cfg_word(cfg_word), .in_valid(in_valid), .in_chan(in_chan),
    .in_byte(in_byte), .in_xlate(in_xlate), .out_valid(out_valid),
    .out_byte(out_byte)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int dmask(input int c);
    case (c) 0: return 0; 1: return 'h55; 2: return 'hAA; default: return 'hFF; endcase
  endfunction

  function automatic int vmask(input int c);
    case (c) 0: return 'h55; 1: return 'h7F; default: return 0; endcase
  endfunction

  // R5 expansion.
  function automatic int expand(input bit mu, input int m);
    int s = m / 16, t = m % 16;
    if (mu) return (2*t + 33) * (1 << s) - 33;
    if (s == 0) return 4*t + 2;
    return (2*t + 33) * (1 << s);
  endfunction

  // R6 lower decision edge.
  function automatic int edge_lo(input bit mu, input int m);
    int s = m / 16, t = m % 16, v;
    if (mu) begin
      v = (t + 16) * (1 << (s + 1)) - 33;
      return (v < 0) ? 0 : v;
    end
    if (s == 0) return 4*t;
    return (t + 16) * (1 << (s + 1));
  endfunction

  function automatic int model(input int cfg, input int b);
    int il = (cfg >> 2) & 3, ol = cfg & 3, canon, mag, best;
    if (cfg[4]) return b ^ dmask(il) ^ dmask(ol);
    canon = b ^ vmask(il);
    mag   = expand(il[0], canon & 'h7F);
    best  = 0;
    for (int m = 0; m < 128; m++) if (edge_lo(ol[0], m) <= mag) best = m;
    return ((canon & 'h80) | best) ^ vmask(ol);
  endfunction

  task automatic write_cfg(input int ch, input int word);
    cfg_we = 1'b1; cfg_chan = 5'(ch); cfg_word = 16'(word);
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Called at a falling edge; returns at the falling edge after the result.
  task automatic send(input int ch, input int b, input bit xl);
    in_valid = 1'b1; in_chan = 5'(ch); in_byte = 8'(b); in_xlate = xl;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_chan = '0; cfg_word = '0;
    in_valid = 1'b0; in_chan = '0; in_byte = '0; in_xlate = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state and default entries
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 out_byte", int'(out_byte), 0);
    send(5, 'h9C, 1'b1);
    chk("R1 default entry", int'(out_byte), 'h9C);
    send(31, 'h03, 1'b1);
    chk("R1 default entry", int'(out_byte), 'h03);

    // R9 hold while idle
    in_byte = 8'h5A;
    @(posedge clk); @(negedge clk);
    chk("R9 idle valid", int'(out_valid), 0);
    chk("R9 idle hold", int'(out_byte), 'h03);

    // Channel number equals its 5-bit control word.
    for (int ch = 0; ch < 32; ch++) write_cfg(ch, ch);

    // R3 R4 R5 R6 R7 R9 sweep over every law pair and byte
    for (int b = 0; b < 256; b++) begin
      for (int ch = 0; ch < 32; ch++) begin
        send(ch, b, 1'b1);
        chk("R9 valid", int'(out_valid), 1);
        if (ch[4])                          chk("R3 data", int'(out_byte), model(ch, b));
        else if (((ch >> 2) & 3) == (ch & 3)) chk("R7 same law", int'(out_byte), b);
        else                                chk("R4 R5 R6 voice", int'(out_byte), model(ch, b));
      end
    end

    // R8 translation off on every kind of channel
    for (int ch = 0; ch < 32; ch += 3) begin
      send(ch, 'hD7, 1'b0);
      chk("R8 raw pass", int'(out_byte), 'hD7);
    end

    // R2 upper bits ignored: 0xFFF4 -> data, in mask 0x55, out mask 0
    write_cfg(7, 'hFFF4);
    send(7, 'h12, 1'b1);
    chk("R2 upper bits", int'(out_byte), 'h12 ^ 'h55);

    // R10 write and sample on the same channel in one cycle
    write_cfg(3, 0);
    cfg_we = 1'b1; cfg_chan = 5'd3; cfg_word = 16'h0014;
    send(3, 'h12, 1'b1);
    cfg_we = 1'b0;
    chk("R10 old entry", int'(out_byte), 'h12);
    send(3, 'h12, 1'b1);
    chk("R10 new entry", int'(out_byte), 'h12 ^ 'h55);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule